// File: doc/BRIEF.md
# Random Number Generator Controller Register Block

This block is the register-facing side of a random number generator peripheral attached to a simple 32-bit memory-mapped bus. Software reads a fixed identification word, writes command bits to start a seeding operation or a self-test, programs a small control register holding interrupt masks and an auto-seed flag, polls a status word, and pulls random words from a data register. Each of the two long-running operations is tracked by its own three-state machine (idle, running, done). An operation runs for a fixed, parameterised number of clock cycles and then completes.

On completion the block raises a level interrupt unless completion interrupts are masked. Software lowers the interrupt through either of two clear command bits, and may return the block to its initial state with a soft reset command. Random words come from an internal 32-bit linear feedback shift register that advances by one step on each data-register read. The status word presents a permanently full data queue of depth five and a seed that is always available, so polling software never waits on them.

The bus is a single-cycle interface: a request with a write flag, a byte address, write data, and read data that is valid combinationally in the cycle of a read request. Register state changes at the clock edge that ends a write cycle.

Top module: `rng_ctrl_regs`

## Requirements
- R1: A read at byte offset 0x00 returns 0x1000_0240: value 1 in bits 31:28, 0x02 in bits 15:8, 0x40 in bits 7:0, all other bits 0.
- R2: Mapped offsets are 0x00 (identification), 0x04 (command), 0x08 (control), 0x0C (status) and 0x14 (data); a read of any other offset returns 0, and writes to offsets 0x00, 0x0C or any unmapped offset change no register.
- R3: Writing a one to command bit 1 starts seeding and to command bit 0 starts the self-test; a command read returns bit 1 set while seeding runs and bit 0 set while the self-test runs, with all other bits 0.
- R4: Writing a one to command bit 4 or to command bit 5 drives the interrupt output low from the next cycle, provided no operation completes in that cycle.
- R5: Control bit 6 (error mask), bit 5 (completion mask) and bit 4 (auto-seed) are read/write; every other control bit reads 0 whatever was written.
- R6: A status read always shows 5 in bits 15:12, 5 in bits 11:8 and 1 in bit 6; bits 31:16, 7, 3 and 2 (including all error indications) always read 0.
- R7: Status bit 5 is 1 when seeding is done, bit 4 is 1 when the self-test is done, bit 1 is 1 while either operation runs, and bit 0 is the inverse of bit 1.
- R8: An operation is running for exactly RUN_CYCLES cycles after the write that starts it and is done from then on; a new start write while it runs restarts the full count.
- R9: The interrupt output is registered and rises at the clock edge where an operation becomes done if the completion mask is 0 at that time; a clear command in that same cycle does not prevent the rise.
- R10: Command bit 6 (soft reset) returns both operations to idle and clears the three control bits, leaves the interrupt output unchanged, and start bits written in the same word still take effect.
- R11: A data read at 0x14 returns the current generator state and then advances it one step, next = {s[30:0], s[31]^s[21]^s[1]^s[0]}; the state after reset is SEED, and no other access advances it.
- R12: Hardware reset puts both operations in idle, clears the control bits, drives the interrupt low and loads the generator with SEED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request |
| irq_o | output | 1 | Level completion interrupt |

## Verification
The bench builds the block with RUN_CYCLES set to 5 and a seed of 0xACE1_2345, so every operation finishes within a handful of bus cycles. The short run length puts exact-length counting, restart part-way through a run, and a clear command landing on the very completion edge within a few directed steps. The non-trivial seed makes each data word distinguishable, so an unexpected extra or missing generator step shows up as a mismatch on the next read.

// File: rtl/rngc_pkg.sv
package rngc_pkg;

    // register byte offsets (software-visible map)
    localparam int unsigned OFS_IDENT = 32'h00;
    localparam int unsigned OFS_CMD   = 32'h04;
    localparam int unsigned OFS_CTRL  = 32'h08;
    localparam int unsigned OFS_STAT  = 32'h0C;
    localparam int unsigned OFS_DATA  = 32'h14;

    // command bit positions
    localparam int unsigned CMD_SOFT_RST = 6;
    localparam int unsigned CMD_CLR_ERR  = 5;
    localparam int unsigned CMD_CLR_IRQ  = 4;
    localparam int unsigned CMD_SEED_GO  = 1;
    localparam int unsigned CMD_TEST_GO  = 0;

    // control bit positions
    localparam int unsigned CTL_MASK_ERR  = 6;
    localparam int unsigned CTL_MASK_DONE = 5;
    localparam int unsigned CTL_AUTO_SEED = 4;

    // status bit positions
    localparam int unsigned ST_SEED_AVAIL = 6;
    localparam int unsigned ST_SEED_DONE  = 5;
    localparam int unsigned ST_TEST_DONE  = 4;
    localparam int unsigned ST_BUSY       = 1;
    localparam int unsigned ST_READY      = 0;

    // identification and reported queue geometry
    localparam logic [3:0] ID_TYPE   = 4'h1;
    localparam logic [7:0] ID_MAJOR  = 8'h02;
    localparam logic [7:0] ID_MINOR  = 8'h40;
    localparam logic [3:0] Q_DEPTH   = 4'd5;
    localparam logic [31:0] IDENT_WORD = {ID_TYPE, 12'h000, ID_MAJOR, ID_MINOR};

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RUN  = 2'd1,
        OP_DONE = 2'd2
    } op_state_e;

    typedef struct packed {
        logic mask_err;
        logic mask_done;
        logic auto_seed;
        logic irq;
    } ctl_regs_t;

endpackage

// File: rtl/rngc_op_tracker.sv
module rngc_op_tracker
    import rngc_pkg::*;
#(
    parameter int unsigned RUN_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      abort_i,
    output op_state_e state_o,
    output logic      finish_o
);

    localparam int unsigned CNT_W = (RUN_CYCLES > 1) ? $clog2(RUN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_CYCLES - 1);

    typedef struct packed {
        op_state_e        st;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_q, trk_d;
    logic finish_d;

    always_comb begin
        trk_d    = trk_q;
        finish_d = 1'b0;
        if (start_i) begin
            // start (or restart) wins over a soft reset in the same write
            trk_d.st  = OP_RUN;
            trk_d.cnt = '0;
        end else if (abort_i) begin
            trk_d.st  = OP_IDLE;
            trk_d.cnt = '0;
        end else if (trk_q.st == OP_RUN) begin
            if (trk_q.cnt == LAST_CNT) begin
                trk_d.st  = OP_DONE;
                trk_d.cnt = '0;
                finish_d  = 1'b1;
            end else begin
                trk_d.cnt = trk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{st: OP_IDLE, cnt: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign state_o  = trk_q.st;
    assign finish_o = finish_d;

endmodule

// File: rtl/rngc_prng.sv
module rngc_prng #(
    parameter int unsigned   WIDTH = 32,
    parameter logic [WIDTH-1:0] SEED = 32'h0000_0001,
    parameter logic [WIDTH-1:0] TAPS = 32'h8020_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [WIDTH-1:0] value_o
);

    logic [WIDTH-1:0] lfsr_q, lfsr_d;
    logic             fb;

    always_comb begin
        fb     = ^(lfsr_q & TAPS);
        lfsr_d = lfsr_q;
        if (step_i) begin
            lfsr_d = {lfsr_q[WIDTH-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign value_o = lfsr_q;

endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
    import rngc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned RUN_CYCLES = 16,
    parameter logic [31:0] SEED       = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(OFS_IDENT);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);

    // decoded bus events
    logic wr_cmd, wr_ctrl, rd_data;
    logic soft_rst, clr_irq, seed_go, test_go;
    logic wdata_unused;

    // operation trackers and generator
    op_state_e   seed_st, test_st;
    logic        seed_fin, test_fin;
    logic        busy;
    logic [31:0] prng_val;
    logic        mask_done_w;

    ctl_regs_t regs_q, regs_d;

    assign wr_cmd  = bus_req &&  bus_we && (bus_addr == A_CMD);
    assign wr_ctrl = bus_req &&  bus_we && (bus_addr == A_CTRL);
    assign rd_data = bus_req && !bus_we && (bus_addr == A_DATA);

    assign soft_rst = wr_cmd && bus_wdata[CMD_SOFT_RST];
    assign clr_irq  = wr_cmd && (bus_wdata[CMD_CLR_ERR] || bus_wdata[CMD_CLR_IRQ]);
    assign seed_go  = wr_cmd && bus_wdata[CMD_SEED_GO];
    assign test_go  = wr_cmd && bus_wdata[CMD_TEST_GO];

    assign wdata_unused = ^{bus_wdata[31:7], bus_wdata[3:2]};

    rngc_op_tracker #(
        .RUN_CYCLES (RUN_CYCLES)
    ) i_seed_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (seed_go),
        .abort_i  (soft_rst),
        .state_o  (seed_st),
        .finish_o (seed_fin)
    );

    rngc_op_tracker #(
        .RUN_CYCLES (RUN_CYCLES)
    ) i_test_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (test_go),
        .abort_i  (soft_rst),
        .state_o  (test_st),
        .finish_o (test_fin)
    );

    rngc_prng #(
        .WIDTH (32),
        .SEED  (SEED),
        .TAPS  (32'h8020_0003)
    ) i_prng (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (rd_data),
        .value_o (prng_val)
    );

    assign busy = (seed_st == OP_RUN) || (test_st == OP_RUN);

    // next-state for control bits and interrupt
    always_comb begin
        regs_d = regs_q;
        if (soft_rst) begin
            regs_d.mask_err  = 1'b0;
            regs_d.mask_done = 1'b0;
            regs_d.auto_seed = 1'b0;
        end
        if (wr_ctrl) begin
            regs_d.mask_err  = bus_wdata[CTL_MASK_ERR];
            regs_d.mask_done = bus_wdata[CTL_MASK_DONE];
            regs_d.auto_seed = bus_wdata[CTL_AUTO_SEED];
        end
        if (clr_irq) begin
            regs_d.irq = 1'b0;
        end
        // completion takes priority over a clear in the same cycle
        if ((seed_fin || test_fin) && !regs_q.mask_done) begin
            regs_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            case (bus_addr)
                A_IDENT: bus_rdata = IDENT_WORD;
                A_CMD: begin
                    bus_rdata[CMD_SEED_GO] = (seed_st == OP_RUN);
                    bus_rdata[CMD_TEST_GO] = (test_st == OP_RUN);
                end
                A_CTRL: begin
                    bus_rdata[CTL_MASK_ERR]  = regs_q.mask_err;
                    bus_rdata[CTL_MASK_DONE] = regs_q.mask_done;
                    bus_rdata[CTL_AUTO_SEED] = regs_q.auto_seed;
                end
                A_STAT: begin
                    bus_rdata[15:12]         = Q_DEPTH;
                    bus_rdata[11:8]          = Q_DEPTH;
                    bus_rdata[ST_SEED_AVAIL] = 1'b1;
                    bus_rdata[ST_SEED_DONE]  = (seed_st == OP_DONE);
                    bus_rdata[ST_TEST_DONE]  = (test_st == OP_DONE);
                    bus_rdata[ST_BUSY]       = busy;
                    bus_rdata[ST_READY]      = !busy;
                end
                A_DATA:  bus_rdata = prng_val;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq_o       = regs_q.irq;
    assign mask_done_w = regs_q.mask_done;

endmodule

// File: rtl/rngc_regs_checker.sv
module rngc_regs_checker
    import rngc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_o,
    input logic              mask_done,
    input logic              seed_fin,
    input logic              test_fin,
    input op_state_e         seed_st,
    input op_state_e         test_st,
    input logic [31:0]       prng_val
);

    logic stat_rd, cmd_wr, clr_cmd, fin_any;

    assign stat_rd = bus_req && !bus_we && (bus_addr == ADDR_W'(OFS_STAT));
    assign cmd_wr  = bus_req &&  bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign clr_cmd = cmd_wr && (bus_wdata[5] || bus_wdata[4]);
    assign fin_any = seed_fin || test_fin;

    // R7: ready and busy are never both set nor both clear
    a_r7_busy_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> (bus_rdata[1] != bus_rdata[0]));

    // R6: constant status fields
    a_r6_status_const: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> (bus_rdata[15:8] == 8'h55 && bus_rdata[6] && bus_rdata[31:16] == 16'h0
                     && !bus_rdata[7] && bus_rdata[3:2] == 2'b00));

    // R9: interrupt only rises after an unmasked completion
    a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(fin_any) && !$past(mask_done)));

    // R9: completion beats a simultaneous clear
    a_r9_completion_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && fin_any && !mask_done) |=> irq_o);

    // R4: clear lowers the interrupt when nothing completes
    a_r4_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && !fin_any) |=> !irq_o);

    // R10: soft reset without start bits idles both operations and the mask
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[6] && !bus_wdata[1] && !bus_wdata[0])
        |=> (seed_st == OP_IDLE && test_st == OP_IDLE && !mask_done));

    // R11: generator never reaches the all-zero lock-up state
    a_r11_prng_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        prng_val != 32'h0);

endmodule

bind rng_ctrl_regs rngc_regs_checker #(
    .ADDR_W (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .mask_done (mask_done_w),
    .seed_fin  (seed_fin),
    .test_fin  (test_fin),
    .seed_st   (seed_st),
    .test_st   (test_st),
    .prng_val  (prng_val)
);

// File: tb/test_rng_ctrl_regs.sv
module test_rng_ctrl_regs;

    localparam int unsigned RUNC = 5;
    localparam logic [31:0] SEED = 32'hACE1_2345;
    localparam int NV = 20;

    // vector: {we, addr, wdata, expected, check}
    localparam logic [73:0] VECS [NV] = '{
        {1'b0, 8'h00, 32'h0,         32'h1000_0240, 1'b1},  // R1 identification
        {1'b0, 8'h04, 32'h0,         32'h0,         1'b1},  // R3 command idle
        {1'b0, 8'h08, 32'h0,         32'h0,         1'b1},  // R12 control after reset
        {1'b0, 8'h0C, 32'h0,         32'h0000_5541, 1'b1},  // R6 R7 status idle
        {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,         1'b0},
        {1'b0, 8'h08, 32'h0,         32'h0000_0070, 1'b1},  // R5 only three bits stick
        {1'b1, 8'h08, 32'h0000_0020, 32'h0,         1'b0},
        {1'b0, 8'h08, 32'h0,         32'h0000_0020, 1'b1},  // R5
        {1'b1, 8'h08, 32'h0000_0050, 32'h0,         1'b0},
        {1'b0, 8'h08, 32'h0,         32'h0000_0050, 1'b1},  // R5
        {1'b0, 8'h10, 32'h0,         32'h0,         1'b1},  // R2 unmapped read
        {1'b0, 8'hFC, 32'h0,         32'h0,         1'b1},  // R2 unmapped read
        {1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0,         1'b0},
        {1'b0, 8'h0C, 32'h0,         32'h0000_5541, 1'b1},  // R2 status is read-only
        {1'b1, 8'h00, 32'h0,         32'h0,         1'b0},
        {1'b0, 8'h00, 32'h0,         32'h1000_0240, 1'b1},  // R2 identification is read-only
        {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,         1'b0},
        {1'b0, 8'h08, 32'h0,         32'h0000_0050, 1'b1},  // R2 unmapped write ignored
        {1'b1, 8'h08, 32'h0,         32'h0,         1'b0},
        {1'b0, 8'h08, 32'h0,         32'h0,         1'b1}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model;

    always #4 clk = ~clk;

    rng_ctrl_regs #(
        .ADDR_W     (8),
        .RUN_CYCLES (RUNC),
        .SEED       (SEED)
    ) i_rng_ctrl_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        r = bus_rdata;
        @(posedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r;
        xfer(1'b1, a, d, r);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] r;
        xfer(1'b0, a, 32'h0, r);
        check(tag, r, exp);
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk);
        bus_req = 1'b0;
        #1;
        check(tag, {31'h0, irq_o}, {31'h0, exp});
    endtask

    // reads status every cycle until done bit bp is set; returns cycles seen busy
    task automatic wait_done(input int bp, output int busy_cnt);
        logic [31:0] r;
        busy_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            xfer(1'b0, 8'h0C, 32'h0, r);
            if (r[1]) busy_cnt++;
            if (r[bp]) break;
        end
    endtask

    task automatic hw_reset();
        @(negedge clk);
        bus_req = 1'b0; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = SEED;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        rst_n = 1'b0;
        model = SEED;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        irq_chk(1'b0, "R12 irq low after reset");

        for (int v = 0; v < NV; v++) begin
            logic [31:0] r;
            xfer(VECS[v][73], VECS[v][72:65], VECS[v][64:33], r);
            if (VECS[v][0]) check($sformatf("vector %0d", v), r, VECS[v][32:1]);
        end

        // R11 generator sequence, only data reads advance it
        for (int k = 0; k < 3; k++) begin
            rd_chk(8'h14, model, "R11 data word");
            model = step(model);
        end
        rd_chk(8'h0C, 32'h0000_5541, "R11 status read between data reads");
        wr(8'h14, 32'hDEAD_BEEF);
        rd_chk(8'h14, model, "R11 no step on other accesses");
        model = step(model);

        // R8 seeding length, R7 done bit, R9 interrupt
        wr(8'h04, 32'h2);
        wait_done(5, cnt);
        check("R8 seed run length", cnt, RUNC);
        rd_chk(8'h0C, 32'h0000_5561, "R7 seed done status");
        irq_chk(1'b1, "R9 irq after seed done");
        rd_chk(8'h04, 32'h0, "R3 command idle after done");

        wr(8'h04, 32'h10);
        irq_chk(1'b0, "R4 clear-interrupt bit");

        // self-test readback, busy, clear via error bit
        wr(8'h04, 32'h1);
        rd_chk(8'h04, 32'h1, "R3 self-test running readback");
        rd_chk(8'h0C, 32'h0000_5562, "R7 busy while running");
        wait_done(4, cnt);
        rd_chk(8'h0C, 32'h0000_5571, "R7 both done");
        irq_chk(1'b1, "R9 irq after self-test done");
        wr(8'h04, 32'h20);
        irq_chk(1'b0, "R4 clear-error bit");

        // masked completion
        wr(8'h08, 32'h20);
        wr(8'h04, 32'h2);
        wait_done(5, cnt);
        irq_chk(1'b0, "R9 masked completion keeps irq low");
        wr(8'h08, 32'h0);

        // restart part-way through
        wr(8'h04, 32'h1);
        for (int k = 0; k < 3; k++) rd_chk(8'h04, 32'h1, "R8 running before restart");
        wr(8'h04, 32'h1);
        wait_done(4, cnt);
        check("R8 restart length", cnt, RUNC);
        wr(8'h04, 32'h10);

        // completion and clear in the same cycle
        wr(8'h04, 32'h2);
        for (int k = 0; k < int'(RUNC) - 1; k++) rd_chk(8'h04, 32'h2, "R3 seed running readback");
        wr(8'h04, 32'h10);
        irq_chk(1'b1, "R9 completion beats clear");

        // soft reset
        wr(8'h08, 32'h70);
        wr(8'h04, 32'h1);
        wr(8'h04, 32'h40);
        rd_chk(8'h08, 32'h0, "R10 control cleared");
        rd_chk(8'h04, 32'h0, "R10 operations idle");
        rd_chk(8'h0C, 32'h0000_5541, "R10 status idle");
        irq_chk(1'b1, "R10 irq unchanged by soft reset");
        wr(8'h04, 32'h42);
        rd_chk(8'h04, 32'h2, "R10 start in same write as soft reset");
        wait_done(5, cnt);
        wr(8'h04, 32'h10);
        irq_chk(1'b0, "R4 clear after soft reset test");

        // hardware reset in the middle of activity
        wr(8'h08, 32'h70);
        wr(8'h04, 32'h3);
        rd_chk(8'h14, model, "R11 data word before reset");
        hw_reset();
        rd_chk(8'h08, 32'h0, "R12 control after reset");
        rd_chk(8'h04, 32'h0, "R12 operations idle");
        rd_chk(8'h0C, 32'h0000_5541, "R12 status idle");
        irq_chk(1'b0, "R12 irq low");
        rd_chk(8'h14, SEED, "R12 generator reloaded");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule